// File: doc/BRIEF.md
# Shift, Bit and Status Flag Unit

This block is the one-clock shift and bit-manipulation datapath of a small 8-bit processor core, and it holds the core's 8-bit status register. Each cycle the core may present an operand, an operation code, a bit index and a flag index with `op_valid` raised. On the next rising clock edge the unit registers the result and the updated status register. Both are visible on its outputs for the whole following cycle, and `result_valid` is high for that cycle.

The operations are logical shifts left and right, rotates left and right through carry, arithmetic shift right, and nibble swap. There are also two bit transfers through the T flag: copying an operand bit into T, and writing T into one operand bit. Finally, any single status flag can be forced to 1 or 0. Each operation touches only its own set of flags. Arithmetic add and subtract are handled elsewhere in the core.

The status register bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6 and I=7. The flag index selects a flag by this position.

Top module: `shift_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after reset is released, `result`, `sreg` and `result_valid` are 0 until the first accepted operation.
- R2: Operation code 0 (shift left) gives `result` = operand shifted up one place with 0 in bit 0, and C = old operand bit 7.
- R3: Operation code 1 (logical shift right) gives `result` = operand shifted down one place with 0 in bit 7, and C = old operand bit 0.
- R4: Code 2 (rotate left) puts the old C into bit 0 and the old bit 7 into C. Code 3 (rotate right) puts the old C into bit 7 and the old bit 0 into C.
- R5: Code 4 (arithmetic shift right) moves bits 7..1 to bits 6..0, keeps bit 7, and sets C to the old bit 0.
- R6: After codes 0 to 4, N equals result bit 7, Z is 1 exactly when the result is zero, V = N xor C (using the new C), and S = N xor V. H, T and I are unchanged.
- R7: Code 5 (swap) exchanges the operand's upper and lower nibbles and leaves all eight flags unchanged.
- R8: Code 6 (bit store) copies operand bit `bit_idx` into T (bit 6) and leaves the other flags unchanged. `result` equals the operand.
- R9: Code 7 (bit load) gives `result` = operand with bit `bit_idx` replaced by the current T. The other result bits and all flags are unchanged.
- R10: Code 8 sets and code 9 clears the status bit at position `flag_idx`. All other status bits are unchanged, and `result` equals the operand.
- R11: An operation takes exactly one clock. `result_valid` is high in the cycle after an accepted operation and low in the cycle after one with `op_valid` low. With `op_valid` low, `result` and `sreg` hold their values.
- R12: Codes 10 to 15 give `result` = operand and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Operation code (0..9; 10..15 pass through) |
| operand | input | 8 | Operand value |
| bit_idx | input | 3 | Operand bit used by bit store and bit load |
| flag_idx | input | 3 | Status bit selected by flag set and flag clear |
| result | output | 8 | Registered result of the last operation |
| result_valid | output | 1 | High in the cycle after an accepted operation |
| sreg | output | 8 | Status register {I,T,H,S,V,N,Z,C} |

## Verification
The assertions check the following on every cycle: holding and the valid timing when idle, and the internal consistency of N, Z, V and S after every shift or rotate. They also check the carry taken from the correct operand bit, bit 7 kept by arithmetic shift, and the flags left unchanged by swap, bit load and unused codes. Single-flag set and clear are checked against the previous status value. The bench scenarios cover what needs history across operations: a carry produced by one operation feeding the next rotate, and a T value stored by one operation and loaded by a later one. They also show that the register's contents are correct at each step of long mixed sequences, compared with an independent model.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    localparam int SREG_W = 8;
    localparam int FIDX_W = $clog2(SREG_W);

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_S = 4;
    localparam int FLG_H = 5;
    localparam int FLG_T = 6;
    localparam int FLG_I = 7;

    typedef enum logic [3:0] {
        OP_SHL  = 4'd0,
        OP_SHR  = 4'd1,
        OP_RTL  = 4'd2,
        OP_RTR  = 4'd3,
        OP_SAR  = 4'd4,
        OP_NSW  = 4'd5,
        OP_TST  = 4'd6,
        OP_TLD  = 4'd7,
        OP_FON  = 4'd8,
        OP_FOFF = 4'd9
    } sfu_op_e;

    function automatic logic op_is_shift(input logic [3:0] code);
        return code <= 4'(OP_SAR);
    endfunction

endpackage

// File: rtl/sfu_shifter.sv
module sfu_shifter
    import sfu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] src,
    input  logic              carry_in,
    output logic [DATA_W-1:0] shifted,
    output logic              carry_out
);

    always_comb begin
        shifted   = src;
        carry_out = carry_in;
        unique case (op_code)
            4'(OP_SHL): begin
                shifted   = {src[DATA_W-2:0], 1'b0};
                carry_out = src[DATA_W-1];
            end
            4'(OP_SHR): begin
                shifted   = {1'b0, src[DATA_W-1:1]};
                carry_out = src[0];
            end
            4'(OP_RTL): begin
                shifted   = {src[DATA_W-2:0], carry_in};
                carry_out = src[DATA_W-1];
            end
            4'(OP_RTR): begin
                shifted   = {carry_in, src[DATA_W-1:1]};
                carry_out = src[0];
            end
            4'(OP_SAR): begin
                shifted   = {src[DATA_W-1], src[DATA_W-1:1]};
                carry_out = src[0];
            end
            default: begin
                shifted   = src;
                carry_out = carry_in;
            end
        endcase
    end

endmodule

// File: rtl/sfu_bitops.sv
module sfu_bitops
    import sfu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W),
    localparam int HALF  = DATA_W / 2
) (
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] src,
    input  logic [IDX_W-1:0]  sel_bit,
    input  logic              t_in,
    output logic [DATA_W-1:0] bit_res,
    output logic              t_pick
);

    logic [DATA_W-1:0] loaded;
    logic [DATA_W-1:0] swapped;

    for (genvar i = 0; i < DATA_W; i++) begin : g_load
        assign loaded[i] = (sel_bit == IDX_W'(i)) ? t_in : src[i];
    end

    assign swapped = {src[HALF-1:0], src[DATA_W-1:HALF]};
    assign t_pick  = src[sel_bit];

    always_comb begin
        unique case (op_code)
            4'(OP_NSW): bit_res = swapped;
            4'(OP_TLD): bit_res = loaded;
            default:    bit_res = src;
        endcase
    end

endmodule

// File: rtl/sfu_flags.sv
module sfu_flags
    import sfu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_code,
    input  logic [SREG_W-1:0] sreg_cur,
    input  logic [FIDX_W-1:0] sel_flag,
    input  logic [DATA_W-1:0] shifted,
    input  logic              carry_out,
    input  logic              t_pick,
    output logic [SREG_W-1:0] sreg_nxt
);

    logic neg_f;
    logic ovf_f;

    assign neg_f = shifted[DATA_W-1];
    assign ovf_f = neg_f ^ carry_out;

    always_comb begin
        sreg_nxt = sreg_cur;
        if (op_is_shift(op_code)) begin
            sreg_nxt[FLG_C] = carry_out;
            sreg_nxt[FLG_Z] = (shifted == '0);
            sreg_nxt[FLG_N] = neg_f;
            sreg_nxt[FLG_V] = ovf_f;
            sreg_nxt[FLG_S] = neg_f ^ ovf_f;
        end else begin
            unique case (op_code)
                4'(OP_TST):  sreg_nxt[FLG_T]    = t_pick;
                4'(OP_FON):  sreg_nxt[sel_flag] = 1'b1;
                4'(OP_FOFF): sreg_nxt[sel_flag] = 1'b0;
                default:     sreg_nxt           = sreg_cur;
            endcase
        end
    end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
    import sfu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [FIDX_W-1:0] flag_idx,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic [SREG_W-1:0] sreg
);

    logic [DATA_W-1:0] shifted;
    logic              carry_out;
    logic [DATA_W-1:0] bit_res;
    logic              t_pick;
    logic [SREG_W-1:0] sreg_nxt;
    logic [DATA_W-1:0] res_nxt;

    sfu_shifter #(.DATA_W(DATA_W)) u_shift (
        .op_code   (op_sel),
        .src       (operand),
        .carry_in  (sreg[FLG_C]),
        .shifted   (shifted),
        .carry_out (carry_out)
    );

    sfu_bitops #(.DATA_W(DATA_W)) u_bits (
        .op_code (op_sel),
        .src     (operand),
        .sel_bit (bit_idx),
        .t_in    (sreg[FLG_T]),
        .bit_res (bit_res),
        .t_pick  (t_pick)
    );

    sfu_flags #(.DATA_W(DATA_W)) u_flags (
        .op_code   (op_sel),
        .sreg_cur  (sreg),
        .sel_flag  (flag_idx),
        .shifted   (shifted),
        .carry_out (carry_out),
        .t_pick    (t_pick),
        .sreg_nxt  (sreg_nxt)
    );

    assign res_nxt = op_is_shift(op_sel) ? shifted : bit_res;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            sreg         <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= op_valid;
            if (op_valid) begin
                result <= res_nxt;
                sreg   <= sreg_nxt;
            end
        end
    end

endmodule

// File: rtl/sfu_checker.sv
module sfu_checker
    import sfu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] operand,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [FIDX_W-1:0] flag_idx,
    input logic [DATA_W-1:0] result,
    input logic              result_valid,
    input logic [SREG_W-1:0] sreg
);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !result_valid && $stable(result) && $stable(sreg));

    p_valid_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> result_valid);

    p_shift_nzvs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel <= 4'(OP_SAR)) |=>
            sreg[FLG_N] == result[DATA_W-1] &&
            sreg[FLG_Z] == (result == '0) &&
            sreg[FLG_V] == (sreg[FLG_N] ^ sreg[FLG_C]) &&
            sreg[FLG_S] == (sreg[FLG_N] ^ sreg[FLG_V]) &&
            sreg[7:5] == $past(sreg[7:5]));

    p_shl_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'(OP_SHL)) |=>
            sreg[FLG_C] == $past(operand[DATA_W-1]) && result[0] == 1'b0);

    p_shr_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'(OP_SHR)) |=>
            sreg[FLG_C] == $past(operand[0]) && result[DATA_W-1] == 1'b0);

    p_rol_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'(OP_RTL)) |=>
            result[0] == $past(sreg[FLG_C]) && sreg[FLG_C] == $past(operand[DATA_W-1]));

    p_sar_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'(OP_SAR)) |=>
            result[DATA_W-1] == $past(operand[DATA_W-1]) &&
            result[DATA_W-2] == $past(operand[DATA_W-1]));

    p_swap_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'(OP_NSW)) |=> $stable(sreg));

    p_bld_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'(OP_TLD)) |=>
            $stable(sreg) && result[$past(bit_idx)] == sreg[FLG_T]);

    p_fset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'(OP_FON)) |=>
            sreg == ($past(sreg) | (SREG_W'(1) << $past(flag_idx))));

    p_fclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'(OP_FOFF)) |=>
            sreg == ($past(sreg) & ~(SREG_W'(1) << $past(flag_idx))));

    p_unused_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel > 4'(OP_FOFF)) |=>
            $stable(sreg) && result == $past(operand));

endmodule

bind shift_flag_unit sfu_checker #(.DATA_W(DATA_W)) u_sfu_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_sel       (op_sel),
    .operand      (operand),
    .bit_idx      (bit_idx),
    .flag_idx     (flag_idx),
    .result       (result),
    .result_valid (result_valid),
    .sreg         (sreg)
);

// File: tb/tb_shift_flag_unit.sv
`timescale 1ns/1ps
module tb_shift_flag_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] operand = '0;
    logic [2:0] bit_idx = '0;
    logic [2:0] flag_idx = '0;
    logic [7:0] result;
    logic       result_valid;
    logic [7:0] sreg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  m_sreg = '0;
    logic [7:0]  last_res = '0;

    always #2 clk = ~clk;

    shift_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .operand(operand), .bit_idx(bit_idx), .flag_idx(flag_idx),
        .result(result), .result_valid(result_valid), .sreg(sreg)
    );

    function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                          input logic [2:0] bi, input logic [2:0] fi,
                                          input logic [7:0] s);
        logic [7:0] r;
        logic [7:0] ns;
        logic c;
        r = a; ns = s; c = s[0];
        case (op)
            4'd0: begin r = {a[6:0], 1'b0}; c = a[7]; end
            4'd1: begin r = {1'b0, a[7:1]}; c = a[0]; end
            4'd2: begin r = {a[6:0], s[0]}; c = a[7]; end
            4'd3: begin r = {s[0], a[7:1]}; c = a[0]; end
            4'd4: begin r = {a[7], a[7:1]}; c = a[0]; end
            4'd5: r = {a[3:0], a[7:4]};
            4'd6: ns[6] = a[bi];
            4'd7: r[bi] = s[6];
            4'd8: ns[fi] = 1'b1;
            4'd9: ns[fi] = 1'b0;
            default: r = a;
        endcase
        if (op <= 4'd4) begin
            ns[0] = c;
            ns[1] = (r == 8'h00);
            ns[2] = r[7];
            ns[3] = ns[2] ^ c;
            ns[4] = ns[2] ^ ns[3];
        end
        return {r, ns};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual result=%h sreg=%b expected result=%h sreg=%b",
                     tag, act[15:8], act[7:0], exp[15:8], exp[7:0]);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic [7:0] a,
                          input logic [2:0] bi, input logic [2:0] fi, input string tag);
        logic [15:0] e;
        @(negedge clk);
        op_valid = 1'b1; op_sel = op; operand = a; bit_idx = bi; flag_idx = fi;
        e = model(op, a, bi, fi, m_sreg);
        m_sreg = e[7:0];
        last_res = e[15:8];
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle_check(input logic [3:0] junk_op);
        @(negedge clk);
        op_valid = 1'b0; op_sel = junk_op; operand = 8'h5A;
        @(negedge clk);
        check("R11 idle hold", {result, sreg}, {last_res, m_sreg});
        checks++;
        if (result_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11 valid low: actual=%b expected=0", result_valid);
        end
    endtask

    // monitor: pop expected items as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && result_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R11 unexpected valid: actual=1 expected=0");
                end else begin
                    check(tag_q.pop_front(), {result, sreg}, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        op_valid = 1'b1; op_sel = 4'd8; operand = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1 in reset", {result, sreg}, 16'h0000);
        checks++;
        if (result_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 valid: actual=%b expected=0", result_valid);
        end
        op_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {result, sreg}, 16'h0000);

        run_op(4'd0, 8'h80, 3'd0, 3'd0, "R2 shl to zero");
        run_op(4'd0, 8'h41, 3'd0, 3'd0, "R2 shl neg");
        run_op(4'd1, 8'h01, 3'd0, 3'd0, "R3 shr to zero");
        run_op(4'd1, 8'hFE, 3'd0, 3'd0, "R3 shr");
        run_op(4'd8, 8'h00, 3'd0, 3'd0, "R10 set C");
        run_op(4'd2, 8'h12, 3'd0, 3'd0, "R4 rol carry in");
        run_op(4'd2, 8'h80, 3'd0, 3'd0, "R4 rol carry out");
        run_op(4'd3, 8'h00, 3'd0, 3'd0, "R4 ror carry in");
        run_op(4'd3, 8'h01, 3'd0, 3'd0, "R4 ror carry out");
        run_op(4'd4, 8'h81, 3'd0, 3'd0, "R5 sar neg");
        run_op(4'd4, 8'h40, 3'd0, 3'd0, "R5 sar pos");
        run_op(4'd8, 8'h00, 3'd0, 3'd5, "R10 set H");
        run_op(4'd8, 8'h00, 3'd0, 3'd7, "R10 set I");
        run_op(4'd0, 8'hC0, 3'd0, 3'd0, "R6 H and I kept");
        run_op(4'd5, 8'hA5, 3'd0, 3'd0, "R7 swap");
        run_op(4'd5, 8'h0F, 3'd0, 3'd0, "R7 swap");
        idle_check(4'd8);
        for (int b = 0; b < 8; b++) begin
            run_op(4'd6, 8'h96, 3'(b), 3'd0, "R8 bit store");
            run_op(4'd7, 8'h3C, 3'(7 - b), 3'd0, "R9 bit load");
        end
        for (int f = 0; f < 8; f++) begin
            run_op(4'd8, 8'h11, 3'd0, 3'(f), "R10 flag set");
            run_op(4'd9, 8'h22, 3'd0, 3'(7 - f), "R10 flag clear");
        end
        for (int k = 10; k < 16; k++) begin
            run_op(4'(k), 8'(k * 17), 3'd3, 3'd3, "R12 unused code");
        end
        idle_check(4'd0);
        lfsr = 8'h1D;
        for (int n = 0; n < 12; n++) begin
            for (int op = 0; op < 10; op++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                run_op(4'(op), lfsr, lfsr[2:0], lfsr[5:3], "R6 mixed sequence");
            end
        end
        idle_check(4'd2);
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R11 pending: actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule